// File: doc/BRIEF.md
# Batched Hash Command Sequencer

The sequencer takes one command that asks for one, two or three hash indexes, all of the same operand width (48, 64 or 128 bits). The operands sit back to back in a block of 32-bit request words that starts at the command's base address. The sequencer reads each operand one word per cycle into an input buffer and hands the completed operand to an external hash engine. It then reads the next operand at once, so the hashes follow each other through the engine with no idle gap.

Results come back from the engine in issue order. Each one goes into a two-entry output buffer and is written out one word per cycle to the return words at the same offsets its operand came from, as soon as it arrives. When the last word of the last result has been written, the sequencer raises a single completion pulse and is free for a new command. The hash arithmetic lives in the engine, not here.

Top module: `hseq_top`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` is high, `busy` is low, `cmd_count` is 1, 2 or 3 and `cmd_width` is not 3. `busy` is high in the following cycle.
- R2: Width code 0 means 48 bits, code 1 means 64 bits and code 2 means 128 bits. An operand spans W = 2 words for codes 0 and 1 and W = 4 words for code 2. Operand k, word j is read at `cmd_base + k*W + j`, low word first. One word is read per cycle, and all operands of a command are read in consecutive cycles.
- R3: Word j of an operand lands in bits [32j+31:32j] of `eng_operand`. Bits at or above the operand width are zero.
- R4: `eng_issue` pulses for one cycle, in the cycle after an operand's last word is read, with `eng_width` equal to the command's width code. Successive issues are W cycles apart.
- R5: A result returned with `eng_ret_valid` is cut to the operand width. Its word j is written at `cmd_base + k*W + j`, low word first, one word per cycle, starting in the cycle after the return. No other return address is written.
- R6: Results are written in return order, to result slots 0, 1, 2 in turn. A return that arrives while an earlier result is still being written waits in the output buffer.
- R7: `done` is a one-cycle pulse in the cycle after the last result word is written. It fires exactly once per command, and `busy` is low in that same cycle.
- R8: A command presented while `busy` is high is ignored. It causes no reads, no writes and no extra `done`.
- R9: A command with `cmd_count` = 0 or `cmd_width` = 3 is ignored, and `busy` stays low.
- R10: During and right after reset, `busy`, `done`, `rd_en`, `wr_en` and `eng_issue` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_width | input | 2 | Operand width code (0: 48, 1: 64, 2: 128 bits) |
| cmd_count | input | CNT_W | Number of hashes, 1 to MAX_OPS |
| cmd_base | input | AW | First request/return word address |
| busy | output | 1 | Command in progress; new commands are refused |
| done | output | 1 | One-cycle completion pulse for the whole command |
| rd_en | output | 1 | Request word read strobe |
| rd_addr | output | AW | Request word address |
| rd_data | input | 32 | Request word, valid in the same cycle as rd_addr |
| eng_issue | output | 1 | Operand handed to the hash engine |
| eng_width | output | 2 | Width code that goes with the issued operand |
| eng_operand | output | 128 | Operand, zero above its width |
| eng_ret_valid | input | 1 | Engine returns a result (in issue order) |
| eng_ret_data | input | 128 | Returned hash value |
| wr_en | output | 1 | Return word write strobe |
| wr_addr | output | AW | Return word address |
| wr_data | output | 32 | Return word data |

## Verification
A fetch counter that slips shows up within one cycle as a break in the `rd_addr` sequence, or as a wrong word inside `eng_operand` at the next issue. A writeback index or buffer pointer that goes wrong puts a result word at the wrong return address or in the wrong slot, and this is visible in the return words as soon as that result is written. A wrong completion count moves `done` away from the exact cycle after the last write, or produces no pulse, or two. The bench therefore checks the return image word by word, counts the issues and their spacing, and times `done` against a closed-form latency.

// File: rtl/hseq_pkg.sv
package hseq_pkg;
  localparam int WORD_W    = 32;
  localparam int WIDTH_S   = 48;
  localparam int WIDTH_M   = 64;
  localparam int WIDTH_L   = 128;
  localparam int MAX_WORDS = (WIDTH_L + WORD_W - 1) / WORD_W;
  localparam int WIDX_W    = $clog2(MAX_WORDS);

  typedef enum logic [1:0] {
    HW_SHORT = 2'd0,
    HW_MID   = 2'd1,
    HW_LONG  = 2'd2,
    HW_BAD   = 2'd3
  } hwidth_e;

  function automatic int bits_of(hwidth_e w);
    case (w)
      HW_SHORT: return WIDTH_S;
      HW_MID:   return WIDTH_M;
      default:  return WIDTH_L;
    endcase
  endfunction

  function automatic int words_of(hwidth_e w);
    return (bits_of(w) + WORD_W - 1) / WORD_W;
  endfunction

  function automatic logic [WIDTH_L-1:0] mask_op(hwidth_e w, logic [WIDTH_L-1:0] v);
    logic [WIDTH_L-1:0] r;
    for (int i = 0; i < WIDTH_L; i++) r[i] = (i < bits_of(w)) ? v[i] : 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/hseq_fetch.sv
module hseq_fetch
  import hseq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CNT_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  hwidth_e             width,
  input  logic [CNT_W-1:0]    count,
  input  logic [AW-1:0]       base,
  output logic                rd_en,
  output logic [AW-1:0]       rd_addr,
  input  logic [WORD_W-1:0]   rd_data,
  output logic                issue,
  output logic [WIDTH_L-1:0]  operand
);
  logic               active;
  logic [CNT_W-1:0]   k;
  logic [WIDX_W-1:0]  j;
  logic [WIDX_W-1:0]  last_j;
  logic               last_word;
  logic [WIDTH_L-1:0] ibuf;

  assign last_j    = WIDX_W'(words_of(width) - 1);
  assign last_word = active && (j == last_j);
  assign rd_en     = active;
  assign rd_addr   = base + AW'(k) * AW'(words_of(width)) + AW'(j);
  assign operand   = mask_op(width, ibuf);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      k      <= '0;
      j      <= '0;
      issue  <= 1'b0;
    end else begin
      issue <= last_word;
      if (start) begin
        active <= 1'b1;
        k      <= '0;
        j      <= '0;
      end else if (active) begin
        if (j == last_j) begin
          j <= '0;
          if (k == count - 1'b1) active <= 1'b0;
          else k <= k + 1'b1;
        end else begin
          j <= j + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (active) begin
      if (j == '0) ibuf <= WIDTH_L'(rd_data);
      else ibuf[j*WORD_W +: WORD_W] <= rd_data;
    end
  end

  p_issue_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue);
  p_rd_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));
endmodule

// File: rtl/hseq_wb.sv
module hseq_wb
  import hseq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CNT_W = 2,
  parameter int DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  hwidth_e            width,
  input  logic [AW-1:0]      base,
  input  logic               ret_valid,
  input  logic [WIDTH_L-1:0] ret_data,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic [WORD_W-1:0]  wr_data,
  output logic               res_last,
  output logic [CNT_W-1:0]   res_idx
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [WIDTH_L-1:0] q [DEPTH];
  logic [PTR_W-1:0]   wp, rp;
  logic [FILL_W-1:0]  fill;
  logic [WIDX_W-1:0]  j;
  logic [WIDX_W-1:0]  last_j;
  logic [WIDTH_L-1:0] head;
  logic               push, pop;

  assign last_j   = WIDX_W'(words_of(width) - 1);
  assign push     = ret_valid;
  assign wr_en    = (fill != '0);
  assign res_last = wr_en && (j == last_j);
  assign pop      = res_last;
  assign head     = q[rp];
  assign wr_data  = head[j*WORD_W +: WORD_W];
  assign wr_addr  = base + AW'(res_idx) * AW'(words_of(width)) + AW'(j);

  always_ff @(posedge clk) begin
    if (push) q[wp] <= mask_op(width, ret_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      fill    <= '0;
      j       <= '0;
      res_idx <= '0;
    end else begin
      if (push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (start) begin
        j       <= '0;
        res_idx <= '0;
      end else if (wr_en) begin
        if (j == last_j) begin
          j       <= '0;
          res_idx <= res_idx + 1'b1;
        end else begin
          j <= j + 1'b1;
        end
      end
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (fill < FILL_W'(DEPTH) || pop));
  p_wr_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));
endmodule

// File: rtl/hseq_top.sv
module hseq_top
  import hseq_pkg::*;
#(
  parameter int AW      = 8,
  parameter int MAX_OPS = 3,
  localparam int CNT_W  = $clog2(MAX_OPS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_width,
  input  logic [CNT_W-1:0]   cmd_count,
  input  logic [AW-1:0]      cmd_base,
  output logic               busy,
  output logic               done,
  output logic               rd_en,
  output logic [AW-1:0]      rd_addr,
  input  logic [WORD_W-1:0]  rd_data,
  output logic               eng_issue,
  output logic [1:0]         eng_width,
  output logic [WIDTH_L-1:0] eng_operand,
  input  logic               eng_ret_valid,
  input  logic [WIDTH_L-1:0] eng_ret_data,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic [WORD_W-1:0]  wr_data
);
  hwidth_e          w_r;
  logic [CNT_W-1:0] cnt_r;
  logic [AW-1:0]    base_r;
  logic             accept, all_done, res_last;
  logic [CNT_W-1:0] res_idx;

  assign accept = cmd_valid && !busy && (cmd_count != '0)
                  && (cmd_count <= CNT_W'(MAX_OPS)) && (hwidth_e'(cmd_width) != HW_BAD);
  assign all_done  = res_last && (res_idx == cnt_r - 1'b1);
  assign eng_width = w_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      w_r    <= HW_SHORT;
      cnt_r  <= '0;
      base_r <= '0;
    end else begin
      done <= all_done;
      if (accept) begin
        busy   <= 1'b1;
        w_r    <= hwidth_e'(cmd_width);
        cnt_r  <= cmd_count;
        base_r <= cmd_base;
      end else if (all_done) begin
        busy <= 1'b0;
      end
    end
  end

  hseq_fetch #(.AW(AW), .CNT_W(CNT_W)) u_fetch (
    .clk, .rst_n, .start(accept), .width(w_r), .count(cnt_r), .base(base_r),
    .rd_en, .rd_addr, .rd_data, .issue(eng_issue), .operand(eng_operand)
  );

  hseq_wb #(.AW(AW), .CNT_W(CNT_W), .DEPTH(2)) u_wb (
    .clk, .rst_n, .start(accept), .width(w_r), .base(base_r),
    .ret_valid(eng_ret_valid), .ret_data(eng_ret_data),
    .wr_en, .wr_addr, .wr_data, .res_last, .res_idx
  );

  p_busy_on_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(rd_en || wr_en || eng_issue));
  p_bad_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && (cmd_count == '0 || cmd_width == 2'd3)) |=> !busy);
endmodule

// File: tb/tb_hseq_top.sv
module tb_hseq_top;
  localparam int ENG_LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_width = 2'd0;
  logic [1:0]   cmd_count = 2'd0;
  logic [7:0]   cmd_base = 8'd0;
  logic         busy, done, rd_en, wr_en, eng_issue, eng_ret_valid;
  logic [7:0]   rd_addr, wr_addr;
  logic [31:0]  rd_data, wr_data;
  logic [1:0]   eng_width;
  logic [127:0] eng_operand, eng_ret_data;

  logic [31:0]  req_mem [256];
  logic [31:0]  ret_mem [256];
  logic         vpipe [ENG_LAT];
  logic [127:0] dpipe [ENG_LAT];

  int checks = 0, failures = 0, cyc = 0;
  int cur_w = 0, cur_n = 0, cur_base = 0;
  int iss_idx = 0, iss_err = 0, gap_err = 0, last_iss = 0;
  int done_cnt = 0, done_at = 0, acc_at = 0, rd_bad = 0, rd_cnt = 0;

  hseq_top dut (
    .clk, .rst_n, .cmd_valid, .cmd_width, .cmd_count, .cmd_base, .busy, .done,
    .rd_en, .rd_addr, .rd_data, .eng_issue, .eng_width, .eng_operand,
    .eng_ret_valid, .eng_ret_data, .wr_en, .wr_addr, .wr_data
  );

  assign rd_data       = req_mem[rd_addr];
  assign eng_ret_valid = vpipe[ENG_LAT-1];
  assign eng_ret_data  = dpipe[ENG_LAT-1];

  function automatic int nwords(int w); return (w == 2) ? 4 : 2; endfunction
  function automatic int nbits(int w); return (w == 0) ? 48 : (w == 1) ? 64 : 128; endfunction
  function automatic logic [31:0] req_word(int a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction
  function automatic logic [127:0] cut(int w, logic [127:0] v);
    logic [127:0] keep = (nbits(w) == 128) ? '1 : ((128'd1 << nbits(w)) - 128'd1);
    return v & keep;
  endfunction
  function automatic logic [127:0] exp_op(int w, int b, int k);
    logic [127:0] op = '0;
    for (int j = 0; j < nwords(w); j++) op[j*32 +: 32] = req_word((b + k*nwords(w) + j) % 256);
    return cut(w, op);
  endfunction

  // stand-in engine: fixed latency, returns the inverted operand unmasked
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENG_LAT; i++) vpipe[i] <= 1'b0;
    end else begin
      vpipe[0] <= eng_issue;
      dpipe[0] <= ~eng_operand;
      for (int i = 1; i < ENG_LAT; i++) begin
        vpipe[i] <= vpipe[i-1];
        dpipe[i] <= dpipe[i-1];
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) ret_mem[wr_addr] = wr_data;
      if (done) begin done_cnt++; done_at = cyc; end
      if (rd_en) begin
        rd_cnt++;
        if (int'(rd_addr) < cur_base || int'(rd_addr) >= cur_base + cur_n*nwords(cur_w)) rd_bad++;
      end
      if (eng_issue) begin
        if (eng_operand !== exp_op(cur_w, cur_base, iss_idx) || int'(eng_width) != cur_w) iss_err++;
        if (iss_idx > 0 && cyc - last_iss != nwords(cur_w)) gap_err++;
        last_iss = cyc;
        iss_idx++;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start_cmd(int w, int n, int b);
    for (int a = 0; a < 256; a++) ret_mem[a] = 32'hDEAD_BEEF;
    cur_w = w; cur_n = n; cur_base = b;
    iss_idx = 0; iss_err = 0; gap_err = 0; done_cnt = 0; rd_bad = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_width = 2'(w); cmd_count = 2'(n); cmd_base = 8'(b);
    acc_at = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1, "R1", "busy after accept", 128'(busy), 128'd1);
  endtask

  task automatic finish_cmd();
    int bad = 0;
    for (int t = 0; t < 300 && done_cnt == 0; t++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(done_cnt == 1, "R7", "done pulse count", 128'(done_cnt), 128'd1);
    chk(done_at - acc_at == cur_n*nwords(cur_w) + nwords(cur_w) + ENG_LAT + 2, "R7",
        "done latency", 128'(done_at - acc_at),
        128'(cur_n*nwords(cur_w) + nwords(cur_w) + ENG_LAT + 2));
    chk(busy === 1'b0, "R7", "busy after done", 128'(busy), 128'd0);
    chk(iss_idx == cur_n && gap_err == 0, "R4", "issue count/spacing", 128'(iss_idx), 128'(cur_n));
    chk(iss_err == 0, "R3", "issued operand/width mismatches", 128'(iss_err), 128'd0);
    chk(rd_bad == 0, "R2", "reads outside operand block", 128'(rd_bad), 128'd0);
    for (int k = 0; k < cur_n; k++)
      for (int j = 0; j < nwords(cur_w); j++) begin
        logic [127:0] r = cut(cur_w, ~exp_op(cur_w, cur_base, k));
        if (ret_mem[(cur_base + k*nwords(cur_w) + j) % 256] !== r[j*32 +: 32]) bad++;
      end
    chk(bad == 0, "R5", "return word mismatches (R6 order)", 128'(bad), 128'd0);
    chk(ret_mem[(cur_base + cur_n*nwords(cur_w)) % 256] === 32'hDEAD_BEEF, "R5",
        "word past return block", 128'(ret_mem[(cur_base + cur_n*nwords(cur_w)) % 256]),
        128'hDEADBEEF);
  endtask

  // width code, count, base
  localparam logic [11:0] VEC [6] = '{
    {2'd0, 2'd1, 8'h00}, {2'd0, 2'd3, 8'h10}, {2'd1, 2'd2, 8'h20},
    {2'd1, 2'd3, 8'h40}, {2'd2, 2'd1, 8'h60}, {2'd2, 2'd3, 8'h80}
  };

  initial begin
    for (int i = 0; i < 10000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) req_mem[a] = req_word(a);
    repeat (3) @(negedge clk);
    chk({busy, done, rd_en, wr_en, eng_issue} === 5'b0, "R10", "outputs in reset",
        128'({busy, done, rd_en, wr_en, eng_issue}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, rd_en, wr_en, eng_issue} === 5'b0, "R10", "outputs after reset",
        128'({busy, done, rd_en, wr_en, eng_issue}), 128'd0);

    for (int v = 0; v < 6; v++) begin
      start_cmd(int'(VEC[v][11:10]), int'(VEC[v][9:8]), int'(VEC[v][7:0]));
      finish_cmd();
    end

    // R8: second command while busy is dropped
    start_cmd(0, 3, 8'hA0);
    repeat (2) @(negedge clk);
    cmd_valid = 1'b1; cmd_width = 2'd1; cmd_count = 2'd2; cmd_base = 8'hC0;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    finish_cmd();
    chk(ret_mem[8'hC0] === 32'hDEAD_BEEF, "R8", "refused command wrote", 128'(ret_mem[8'hC0]),
        128'hDEADBEEF);

    // R9: invalid count and invalid width are ignored
    done_cnt = 0; rd_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_width = 2'd0; cmd_count = 2'd0; cmd_base = 8'h10;
    @(negedge clk);
    cmd_width = 2'd3; cmd_count = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b0, "R9", "busy after invalid command", 128'(busy), 128'd0);
    repeat (20) @(negedge clk);
    chk(rd_cnt == 0 && done_cnt == 0, "R9", "activity after invalid command",
        128'(rd_cnt + done_cnt), 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule